// File: doc/BRIEF.md
# Page-Mode Asynchronous Memory Front End

This block puts a word array behind an SRAM-style asynchronous bus. The bus has an active-low chip enable, write enable and output enable, two active-low byte-lane selects, a 17-bit word address and a 16-bit data path. The data path is split into an input, an output and per-lane drive enables, and pad logic joins them into a bidirectional bus. A fast system clock samples every bus input through a two-flop synchronizer. Edges are detected on the synchronized copies. An access starts when chip enable falls, or when the row part of the address (bits 16:2) changes while chip enable is held low. A precharge interval always separates two row accesses. A change of only the two column bits within an open row gives a shorter page access.

Writes can be controlled by chip enable, when write enable is low as the cycle starts. They can also be controlled by write enable, in which case the cycle starts as a read and write enable falls later. The falling write enable also picks the column for page writes. The write lands when write enable or chip enable rises, whichever rises first, using the data and lane selects present just before that edge. Lanes whose select is high keep their stored byte. A write-inhibit input, driven by external protection logic that decodes the `word_addr` output, blocks the array write for the open word. The array is a plain synchronous memory that uses the low `MEM_AW` bits of the word address.

Top module: `pmem_front`

## Requirements
- R1: While the block is idle, a falling chip enable latches the whole address and starts an access. With write enable high and output enable and both selects low, the addressed word appears on `bus_dq_out` with `bus_dq_oe` = 2'b11. Drive begins exactly ACC_LAT+4 clock cycles after the chip enable change.
- R2: With chip enable low and write enable high, a change of only address bits 1:0 starts a page access in the open row without a precharge. Drive drops and returns with the new column's word exactly PAGE_LAT+4 cycles after the address change.
- R3: With chip enable low, a change in address bits 16:2 closes the row through a precharge. The new word is driven no earlier than PRE_CYC+ACC_LAT cycles after the change.
- R4: A write-enable-controlled write starts as a read and drives the old word if output enable is low. Each falling write enable latches the current column. A column change while write enable stays low does not redirect the write.
- R5: On a write, a lane whose select is high (`bus_ub_n` for bits 15:8, `bus_lb_n` for bits 7:0) keeps its stored byte.
- R6: Write data and lane selects are taken as they stood just before the first rising edge of write enable or chip enable. Data changed after that edge is not stored.
- R7: The data bus is never driven while write enable is low, whatever output enable does.
- R8: `bus_dq_oe[1]` (lane 15:8) is high only with output enable and `bus_ub_n` low, and `bus_dq_oe[0]` (lane 7:0) only with output enable and `bus_lb_n` low. Drive is held off until the access completes, even if output enable fell earlier.
- R9: While `wr_inhibit` is high at the write edge, the array word is left unchanged.
- R10: After chip enable rises, no new access begins until PRE_CYC cycles of precharge have passed, even if chip enable falls again at once.
- R11: During and right after reset, `bus_dq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling and array clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_ce_n | input | 1 | Chip enable, active low |
| bus_we_n | input | 1 | Write enable, active low |
| bus_oe_n | input | 1 | Output enable, active low |
| bus_ub_n | input | 1 | Upper lane select (bits 15:8), active low |
| bus_lb_n | input | 1 | Lower lane select (bits 7:0), active low |
| bus_addr | input | 17 | Word address; bits 1:0 are the column |
| bus_dq_in | input | 16 | Write data from the bus |
| bus_dq_out | output | 16 | Read data toward the bus |
| bus_dq_oe | output | 2 | Per-lane drive enable, bit 1 = bits 15:8 |
| wr_inhibit | input | 1 | Blocks the array write of the open word |
| word_addr | output | 17 | Currently latched word address |

## Verification
The cases hardest to reach from the ports involve two strobes in a set order. One is a write-enable-controlled page write where the column moves while write enable is still low. Another is a write where data changes between the two rising strobes, and a third is a chip enable high for one cycle before falling again. The bench drives these orderings on negedges with fixed cycle gaps. It then reads the words back through normal read cycles. It counts cycles from each address or strobe change to the return of drive, which separates page accesses from precharged ones.

// File: rtl/pmf_pkg.sv
package pmf_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PRE   = 2'd1,
    ST_ACC   = 2'd2,
    ST_VALID = 2'd3
  } pmf_state_t;
endpackage

// File: rtl/pmf_sync.sv
module pmf_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/pmf_array.sv
module pmf_array #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [DW/8-1:0] be,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int NL    = DW / 8;
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < NL; g++) begin : g_lane
    logic [7:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we && be[g]) mem[addr] <= wdata[g*8 +: 8];
      rdata[g*8 +: 8] <= mem[addr];
    end
  end
endmodule

// File: rtl/pmf_ctrl.sv
module pmf_ctrl
  import pmf_pkg::*;
#(
  parameter int ROW_W    = 15,
  parameter int COL_W    = 2,
  parameter int ACC_LAT  = 4,
  parameter int PAGE_LAT = 2,
  parameter int PRE_CYC  = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ce_s,
  input  logic                   we_s,
  input  logic [ROW_W+COL_W-1:0] addr_s,
  output pmf_state_t             state,
  output logic [ROW_W-1:0]       row_q,
  output logic [COL_W-1:0]       col_q,
  output logic                   commit
);
  localparam int M1    = (ACC_LAT > PAGE_LAT) ? ACC_LAT : PAGE_LAT;
  localparam int MAXC  = (M1 > PRE_CYC) ? M1 : PRE_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] ACC_LD  = CNT_W'(ACC_LAT - 1);
  localparam logic [CNT_W-1:0] PAGE_LD = CNT_W'(PAGE_LAT - 1);
  localparam logic [CNT_W-1:0] PRE_LD  = CNT_W'(PRE_CYC - 1);

  logic [CNT_W-1:0] cnt;
  logic             armed;
  logic             ce_q, we_q;
  logic [ROW_W-1:0] row_in;
  logic [COL_W-1:0] col_in;
  logic             we_rise, we_fall, ce_rise, active;

  assign row_in  = addr_s[ROW_W+COL_W-1:COL_W];
  assign col_in  = addr_s[COL_W-1:0];
  assign we_rise = we_s && !we_q;
  assign we_fall = !we_s && we_q;
  assign ce_rise = ce_s && !ce_q;
  assign active  = (state == ST_ACC) || (state == ST_VALID);
  assign commit  = armed && (we_rise || ce_rise);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      row_q <= '0;
      col_q <= '0;
      armed <= 1'b0;
      ce_q  <= 1'b1;
      we_q  <= 1'b1;
    end else begin
      ce_q <= ce_s;
      we_q <= we_s;
      if (commit) armed <= 1'b0;
      else if (active && !ce_s && !we_s) armed <= 1'b1;

      case (state)
        ST_IDLE: begin
          if (!ce_s) begin
            row_q <= row_in;
            col_q <= col_in;
            cnt   <= ACC_LD;
            state <= ST_ACC;
          end
        end
        ST_PRE: begin
          if (cnt == '0) state <= ST_IDLE;
          else cnt <= cnt - 1'b1;
        end
        default: begin
          if (ce_s) begin
            cnt   <= PRE_LD;
            state <= ST_PRE;
          end else if (row_in != row_q) begin
            cnt   <= PRE_LD;
            state <= ST_PRE;
            armed <= 1'b0;
          end else if (we_rise) begin
            cnt   <= PAGE_LD;
            state <= ST_ACC;
          end else if (we_fall) begin
            col_q <= col_in;
          end else if (we_s && col_in != col_q) begin
            col_q <= col_in;
            cnt   <= PAGE_LD;
            state <= ST_ACC;
          end else if (state == ST_ACC) begin
            if (cnt == '0) state <= ST_VALID;
            else cnt <= cnt - 1'b1;
          end
        end
      endcase
    end
  end

  // R10: precharge is never cut short
  assert_pre_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PRE && cnt != '0) |=> state == ST_PRE);

  // R3: a row change with chip enable low always precharges
  assert_row_pre_R3: assert property (@(posedge clk) disable iff (rst)
    (active && !ce_s && row_in != row_q) |=> state == ST_PRE);

  // R2: a column-only change opens a page access on the new column
  assert_col_page_R2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_VALID && !ce_s && row_in == row_q && we_s && we_q && col_in != col_q)
    |=> (state == ST_ACC && col_q == $past(col_in)));
endmodule

// File: rtl/pmem_front.sv
module pmem_front
  import pmf_pkg::*;
#(
  parameter int ADDR_W   = 17,
  parameter int COL_W    = 2,
  parameter int MEM_AW   = 8,
  parameter int ACC_LAT  = 4,
  parameter int PAGE_LAT = 2,
  parameter int PRE_CYC  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_ce_n,
  input  logic              bus_we_n,
  input  logic              bus_oe_n,
  input  logic              bus_ub_n,
  input  logic              bus_lb_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_dq_in,
  output logic [15:0]       bus_dq_out,
  output logic [1:0]        bus_dq_oe,
  input  logic              wr_inhibit,
  output logic [ADDR_W-1:0] word_addr
);
  localparam int DW    = 16;
  localparam int ROW_W = ADDR_W - COL_W;
  localparam int NSTB  = 5;

  logic [NSTB-1:0]   stb_s;
  logic              ce_s, we_s, oe_s, ub_s, lb_s, we_d;
  logic [ADDR_W-1:0] addr_s;
  logic [DW-1:0]     dq_s, hold_data, rdata;
  logic [1:0]        hold_be, lane_sel;
  pmf_state_t        state;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic              commit, mem_we;

  pmf_sync #(.W(NSTB), .RST_VAL({NSTB{1'b1}})) u_sync_stb (
    .clk(clk), .rst(rst),
    .d({bus_ce_n, bus_we_n, bus_oe_n, bus_ub_n, bus_lb_n}), .q(stb_s));
  assign {ce_s, we_s, oe_s, ub_s, lb_s} = stb_s;

  pmf_sync #(.W(ADDR_W), .RST_VAL('0)) u_sync_addr (
    .clk(clk), .rst(rst), .d(bus_addr), .q(addr_s));

  pmf_sync #(.W(DW), .RST_VAL('0)) u_sync_dq (
    .clk(clk), .rst(rst), .d(bus_dq_in), .q(dq_s));

  pmf_ctrl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .ACC_LAT(ACC_LAT),
    .PAGE_LAT(PAGE_LAT), .PRE_CYC(PRE_CYC)
  ) u_ctrl (
    .clk(clk), .rst(rst), .ce_s(ce_s), .we_s(we_s), .addr_s(addr_s),
    .state(state), .row_q(row_q), .col_q(col_q), .commit(commit));

  assign word_addr = {row_q, col_q};
  assign mem_we    = commit && !wr_inhibit;

  pmf_array #(.AW(MEM_AW), .DW(DW)) u_array (
    .clk(clk), .we(mem_we), .be(hold_be), .addr(word_addr[MEM_AW-1:0]),
    .wdata(hold_data), .rdata(rdata));

  // last data and lane selects seen while both strobes were low
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_data <= '0;
      hold_be   <= '0;
      we_d      <= 1'b1;
    end else begin
      we_d <= we_s;
      if (!ce_s && !we_s) begin
        hold_data <= dq_s;
        hold_be   <= {!ub_s, !lb_s};
      end
    end
  end

  assign lane_sel = {!ub_s, !lb_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_dq_out <= '0;
      bus_dq_oe  <= '0;
    end else begin
      bus_dq_out <= rdata;
      for (int i = 0; i < 2; i++)
        bus_dq_oe[i] <= (state == ST_VALID) && !ce_s && we_s && we_d &&
                        !oe_s && lane_sel[i];
    end
  end

  // R7: drive only if write enable was high at the pins three cycles back
  assert_no_drive_we_R7: assert property (@(posedge clk) disable iff (rst)
    (|bus_dq_oe) |-> $past(bus_we_n, 3));

  // R8: drive only if output enable was low at the pins three cycles back
  assert_drive_oe_R8: assert property (@(posedge clk) disable iff (rst)
    (|bus_dq_oe) |-> !$past(bus_oe_n, 3));
endmodule

// File: tb/sim_pmem_front.sv
module sim_pmem_front;
  localparam int ACC_LAT = 4, PAGE_LAT = 2, PRE_CYC = 5;

  logic clk = 0, rst = 1;
  logic ce_n = 1, we_n = 1, oe_n = 1, ub_n = 0, lb_n = 0, inh = 0;
  logic [16:0] addr = '0;
  logic [15:0] dq_in = '0, dq_out;
  logic [1:0]  dq_oe, prev_oe = '0;
  logic [16:0] waddr;

  int checks = 0, errors = 0, cycles = 0;
  logic [17:0] exp_q[$];
  string       tag_q[$];

  pmem_front #(.ACC_LAT(ACC_LAT), .PAGE_LAT(PAGE_LAT), .PRE_CYC(PRE_CYC)) u0 (
    .clk(clk), .rst(rst), .bus_ce_n(ce_n), .bus_we_n(we_n), .bus_oe_n(oe_n),
    .bus_ub_n(ub_n), .bus_lb_n(lb_n), .bus_addr(addr), .bus_dq_in(dq_in),
    .bus_dq_out(dq_out), .bus_dq_oe(dq_oe), .wr_inhibit(inh), .word_addr(waddr));

  always #10 clk = ~clk;

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic push(logic [1:0] lanes, logic [15:0] d, string req);
    exp_q.push_back({lanes, d});
    tag_q.push_back(req);
  endtask

  // monitor: each start of drive consumes one expected item
  always @(negedge clk) begin
    if (!rst && dq_oe != 2'b00 && prev_oe == 2'b00) begin
      if (exp_q.size() == 0) begin
        check(0, "R8", "unexpected drive", int'(dq_oe), 0);
      end else begin
        logic [17:0] e;
        logic [15:0] m;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        m = {{8{e[17]}}, {8{e[16]}}};
        check(dq_oe == e[17:16], t, "lanes", int'(dq_oe), int'(e[17:16]));
        check((dq_out & m) == (e[15:0] & m), t, "data", int'(dq_out & m), int'(e[15:0] & m));
      end
    end
    prev_oe = dq_oe;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected below 150000", cycles);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic ce_write(logic [16:0] a, logic [15:0] d, logic [1:0] sel_n);
    addr = a; dq_in = d; {ub_n, lb_n} = sel_n; we_n = 0;
    tick(2); ce_n = 0;
    tick(8); ce_n = 1;
    tick(2); we_n = 1; ub_n = 0; lb_n = 0;
    tick(10);
  endtask

  task automatic read_acc(logic [16:0] a, logic [1:0] sel_n, logic [15:0] e, string req);
    addr = a; {ub_n, lb_n} = sel_n; oe_n = 0; ce_n = 0;
    push(~sel_n, e, req);
    tick(16); ce_n = 1; oe_n = 1; ub_n = 0; lb_n = 0;
    tick(10);
  endtask

  // cycles until drive is on again after having been off
  task automatic wait_drive(output int n);
    bit seen_off;
    n = 0;
    seen_off = (dq_oe == 2'b00);
    while (n < 200) begin
      tick(1); n++;
      if (dq_oe == 2'b00) seen_off = 1;
      else if (seen_off) break;
    end
  endtask

  initial begin
    int n;
    tick(5);
    check(dq_oe == 2'b00, "R11", "drive in reset", int'(dq_oe), 0);
    rst = 0;
    tick(2);
    check(dq_oe == 2'b00, "R11", "drive after reset", int'(dq_oe), 0);

    ce_write(17'h00010, 16'h1234, 2'b00);
    for (int c = 0; c < 4; c++) ce_write(17'h00020 + 17'(c), 16'hA000 + 16'(c), 2'b00);

    // R1 idle access latency and data
    addr = 17'h00010; oe_n = 0; ce_n = 0; push(2'b11, 16'h1234, "R1");
    wait_drive(n);
    check(n == ACC_LAT + 4, "R1", "idle access latency", n, ACC_LAT + 4);
    tick(4);
    // R3 row change inside one chip-enable window
    addr = 17'h00020; push(2'b11, 16'hA000, "R3");
    wait_drive(n);
    check(n >= PRE_CYC + ACC_LAT, "R3", "row change latency", n, PRE_CYC + ACC_LAT);
    tick(4);
    // R2 page reads
    for (int c = 1; c < 4; c++) begin
      addr = 17'h00020 + 17'(c); push(2'b11, 16'hA000 + 16'(c), "R2");
      wait_drive(n);
      check(n == PAGE_LAT + 4, "R2", "page latency", n, PAGE_LAT + 4);
      tick(3);
    end
    // R10 one-cycle chip enable high
    ce_n = 1; tick(1); ce_n = 0; push(2'b11, 16'hA003, "R10");
    wait_drive(n);
    check(n >= PRE_CYC + ACC_LAT, "R10", "latency after short precharge", n, PRE_CYC + ACC_LAT);
    tick(3); ce_n = 1; oe_n = 1; tick(10);

    // R5 lane masking
    ce_write(17'h00030, 16'hAAAA, 2'b00);
    ce_write(17'h00030, 16'h55CC, 2'b10);
    read_acc(17'h00030, 2'b00, 16'hAACC, "R5");
    ce_write(17'h00030, 16'h7711, 2'b01);
    read_acc(17'h00030, 2'b00, 16'h77CC, "R5");
    // R8 single lane read, then output enable held high
    read_acc(17'h00030, 2'b10, 16'h00CC, "R8");
    read_acc(17'h00030, 2'b01, 16'h7700, "R8");
    addr = 17'h00030; ce_n = 0; n = 0;
    for (int i = 0; i < 16; i++) begin
      tick(1);
      if (dq_oe != 2'b00) n++;
    end
    check(n == 0, "R8", "drive with output enable high", n, 0);
    ce_n = 1; tick(10);

    // R4 / R7 write-enable-controlled write starting as a read
    ce_write(17'h00040, 16'h0F0F, 2'b00);
    addr = 17'h00040; oe_n = 0; ce_n = 0; push(2'b11, 16'h0F0F, "R4");
    tick(16); we_n = 0; tick(4);
    check(dq_oe == 2'b00, "R7", "drive while write enable low", int'(dq_oe), 0);
    dq_in = 16'hBEEF; tick(4);
    check(dq_oe == 2'b00, "R7", "drive while write enable low", int'(dq_oe), 0);
    we_n = 1; push(2'b11, 16'hBEEF, "R4");
    tick(16); ce_n = 1; oe_n = 1; tick(10);

    // R4 page writes; last column moves while write enable stays low
    addr = 17'h00050; ce_n = 0; tick(10);
    for (int c = 0; c < 3; c++) begin
      addr = 17'h00050 + 17'(c); tick(5);
      dq_in = 16'hC000 + 16'(c); we_n = 0; tick(5);
      we_n = 1; tick(6);
    end
    addr = 17'h00053; tick(5);
    dq_in = 16'hC003; we_n = 0; tick(3);
    addr = 17'h00052; tick(4);
    we_n = 1; tick(6);
    ce_n = 1; tick(10);
    for (int c = 0; c < 4; c++) read_acc(17'h00050 + 17'(c), 2'b00, 16'hC000 + 16'(c), "R4");

    // R6 write enable rises first, data then changes
    addr = 17'h00060; dq_in = 16'h1111; we_n = 0; tick(2);
    ce_n = 0; tick(8); we_n = 1; tick(1); dq_in = 16'h2222; tick(6);
    ce_n = 1; tick(10);
    read_acc(17'h00060, 2'b00, 16'h1111, "R6");
    // R6 chip enable rises first, data then changes
    addr = 17'h00061; dq_in = 16'h3333; we_n = 0; tick(2);
    ce_n = 0; tick(8); ce_n = 1; tick(1); dq_in = 16'h4444; tick(4);
    we_n = 1; tick(10);
    read_acc(17'h00061, 2'b00, 16'h3333, "R6");

    // R9 inhibited write
    ce_write(17'h00070, 16'h5A5A, 2'b00);
    inh = 1;
    ce_write(17'h00070, 16'hFFFF, 2'b00);
    inh = 0;
    read_acc(17'h00070, 2'b00, 16'h5A5A, "R9");

    tick(20);
    check(exp_q.size() == 0, "R8", "expected drives left unseen", exp_q.size(), 0);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule